// File: doc/BRIEF.md
# Single-Wire Bus Host Handshake Sequencer

This block sits between a host and the line-timing engine of a single-wire bus master. The host sets two command inputs, a data/clock line and a reset-select line, and then pulls an active-low enable. The block decodes the command on the synchronized enable falling edge. The command is one of four: a high bit slot (read, or write of a one), a write-zero slot, a bus reset, or a toggle of the overdrive speed bit. For a slot or a reset, the block starts the timing engine with a one-cycle pulse and a kind code.

The host sees all progress on two status outputs. In the idle state these outputs pass through two auxiliary inputs. During a bit slot both outputs are held low. During a reset, output 1 is held low at once, while output 2 stays high for a short stage and then also drops low. When the engine reports completion, the outputs follow the auxiliary inputs again, which tells the host the slot is done. The host then lowers the data line to ask for the result. A low result pins both outputs low until the enable is released. A high result leaves the pass-through in place. An overdrive toggle flips the speed bit that the timing engine receives. When the toggle clears the bit, the outputs report it by going low.

Top module: `owh_host_seq`

## Requirements
- R1: The enable, data and reset-select inputs pass through two-flop synchronizers. On a synchronized enable high-to-low transition in the idle state, the pair {data, reset-select} is decoded. 11 starts a slot of kind 0 (high bit). 01 starts kind 1 (write zero). 10 starts kind 2 (bus reset). Each start pulses `eng_start_o` for one cycle, and `eng_kind_o` carries the kind.
- R2: From the start pulse until the engine done strobe, a kind 0 or kind 1 slot holds both status outputs low.
- R3: During a reset, `stat1_o` is low from the start pulse onward. `stat2_o` is high for exactly CLK_PER_US*RST_STAGE_US cycles, beginning with the start-pulse cycle, and is then low until done.
- R4: After `eng_done_i` is sampled high while busy, both status outputs follow `aux1_i`/`aux2_i`. The done strobe takes precedence even if it lands on the reset stage boundary.
- R5: After done, a high-to-low transition of the synchronized data input is a result query. If the captured `eng_result_i` was 0, both outputs are forced low until the enable returns high.
- R6: If the captured result was 1, a query leaves the outputs following the auxiliary inputs.
- R7: A synchronized enable low-to-high transition after done, after a query, or after an overdrive toggle returns the block to idle. In idle the outputs follow the auxiliary inputs.
- R8: Command 00 starts no slot and inverts `speed_o`, which is 0 after reset. If the new value is 1, the outputs follow the auxiliary inputs. If the new value is 0, both outputs are low until the enable returns high.
- R9: While a slot is busy, enable transitions and command changes are ignored. There is no further start pulse, and the kind and the output pattern are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_n_i | input | 1 | Active-low host enable (asynchronous) |
| dat_i | input | 1 | Host data/clock command line (asynchronous) |
| rsel_i | input | 1 | Host reset-select line, low requests a reset (asynchronous) |
| aux1_i | input | 1 | Auxiliary input passed to status output 1 |
| aux2_i | input | 1 | Auxiliary input passed to status output 2 |
| eng_done_i | input | 1 | One-cycle completion strobe from the timing engine |
| eng_result_i | input | 1 | Line result from the engine, valid with done |
| stat1_o | output | 1 | Status/busy output 1 |
| stat2_o | output | 1 | Status/busy output 2 |
| eng_start_o | output | 1 | One-cycle start pulse to the timing engine |
| eng_kind_o | output | 2 | Slot kind: 0 high bit, 1 write zero, 2 reset |
| speed_o | output | 1 | Overdrive speed select to the timing engine |

## Verification
Two functions can collide in one cycle. The engine done strobe can arrive on the same cycle that the reset stage window closes, so the stage timer wants output 2 to fall while the completion logic wants the pass-through. The bench sets the modelled engine's delay so that done lands on that boundary, with both auxiliary inputs high. It then judges that the outputs end up following the auxiliary inputs with no extra start. A second directed case toggles the enable and changes the command in the middle of a busy slot. It checks that neither a new start nor the reset output pattern appears.

// File: rtl/owh_pkg.sv
package owh_pkg;

  typedef enum logic [1:0] {
    KIND_HI  = 2'd0,
    KIND_LO  = 2'd1,
    KIND_RST = 2'd2
  } slot_kind_e;

  typedef enum logic [1:0] {
    CMD_HI,
    CMD_LO,
    CMD_RST,
    CMD_OD
  } host_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BUSY,
    ST_DONE,
    ST_HOLD
  } seq_state_e;

  function automatic host_cmd_e decode_cmd(input logic dat, input logic rsel);
    case ({dat, rsel})
      2'b11:   return CMD_HI;
      2'b01:   return CMD_LO;
      2'b10:   return CMD_RST;
      default: return CMD_OD;
    endcase
  endfunction

  function automatic slot_kind_e cmd_to_kind(input host_cmd_e c);
    case (c)
      CMD_LO:  return KIND_LO;
      CMD_RST: return KIND_RST;
      default: return KIND_HI;
    endcase
  endfunction

  function automatic int unsigned stage_cycles(input int unsigned clk_per_us,
                                               input int unsigned us);
    return clk_per_us * us;
  endfunction

endpackage

// File: rtl/owh_sync.sv
module owh_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= RST_VAL;
    else        pipe[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[s] <= RST_VAL;
      else        pipe[s] <= pipe[s-1];
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/owh_stage_timer.sv
module owh_stage_timer #(
  parameter int unsigned LIMIT = 8,
  localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  output logic window_o
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                cnt <= '0;
    else if (clear_i)                          cnt <= '0;
    else if (run_i && (cnt < CW'(LIMIT)))      cnt <= cnt + 1'b1;
  end

  assign window_o = (cnt < CW'(LIMIT));
endmodule

// File: rtl/owh_seq.sv
module owh_seq
  import owh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_s_i,
  input  logic       dat_s_i,
  input  logic       rsel_s_i,
  input  logic       aux1_i,
  input  logic       aux2_i,
  input  logic       eng_done_i,
  input  logic       eng_result_i,
  input  logic       stage_win_i,
  output logic       stage_clr_o,
  output logic       stage_run_o,
  output logic       stat1_o,
  output logic       stat2_o,
  output logic       eng_start_o,
  output logic [1:0] eng_kind_o,
  output logic       speed_o,
  output logic       fall_ev_o,
  output logic       rise_ev_o,
  output logic       query_ev_o,
  output logic       od_tog_ev_o,
  output logic       idle_o,
  output logic       busy_o
);
  seq_state_e state;
  slot_kind_e kind_q;
  host_cmd_e  cmd;
  logic en_prev, dat_prev, res_q, hold_low_q, od_q, start_q;

  assign cmd         = decode_cmd(dat_s_i, rsel_s_i);
  assign fall_ev_o   = en_prev & ~en_s_i;
  assign rise_ev_o   = ~en_prev & en_s_i;
  assign idle_o      = (state == ST_IDLE);
  assign busy_o      = (state == ST_BUSY);
  assign query_ev_o  = (state == ST_DONE) & dat_prev & ~dat_s_i;
  assign od_tog_ev_o = idle_o & fall_ev_o & (cmd == CMD_OD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_prev  <= 1'b1;
      dat_prev <= 1'b1;
    end else begin
      en_prev  <= en_s_i;
      dat_prev <= dat_s_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      kind_q     <= KIND_HI;
      res_q      <= 1'b1;
      hold_low_q <= 1'b0;
      od_q       <= 1'b0;
      start_q    <= 1'b0;
    end else begin
      start_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (fall_ev_o) begin
            if (cmd == CMD_OD) begin
              od_q       <= ~od_q;
              hold_low_q <= od_q;
              state      <= ST_HOLD;
            end else begin
              kind_q  <= cmd_to_kind(cmd);
              start_q <= 1'b1;
              state   <= ST_BUSY;
            end
          end
        end
        ST_BUSY: begin
          if (eng_done_i) begin
            res_q <= eng_result_i;
            state <= ST_DONE;
          end
        end
        ST_DONE: begin
          if (rise_ev_o) begin
            state <= ST_IDLE;
          end else if (query_ev_o) begin
            hold_low_q <= ~res_q;
            state      <= ST_HOLD;
          end
        end
        default: begin
          if (rise_ev_o) state <= ST_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    stat1_o = aux1_i;
    stat2_o = aux2_i;
    case (state)
      ST_BUSY: begin
        stat1_o = 1'b0;
        stat2_o = (kind_q == KIND_RST) ? stage_win_i : 1'b0;
      end
      ST_HOLD: begin
        if (hold_low_q) begin
          stat1_o = 1'b0;
          stat2_o = 1'b0;
        end
      end
      default: ;
    endcase
  end

  assign stage_clr_o = ~busy_o;
  assign stage_run_o = busy_o & (kind_q == KIND_RST);
  assign eng_start_o = start_q;
  assign eng_kind_o  = kind_q;
  assign speed_o     = od_q;
endmodule

// File: rtl/owh_host_seq.sv
module owh_host_seq
  import owh_pkg::*;
#(
  parameter int unsigned CLK_PER_US   = 4,
  parameter int unsigned RST_STAGE_US = 2,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_n_i,
  input  logic       dat_i,
  input  logic       rsel_i,
  input  logic       aux1_i,
  input  logic       aux2_i,
  input  logic       eng_done_i,
  input  logic       eng_result_i,
  output logic       stat1_o,
  output logic       stat2_o,
  output logic       eng_start_o,
  output logic [1:0] eng_kind_o,
  output logic       speed_o
);
  localparam int unsigned STAGE_LEN = stage_cycles(CLK_PER_US, RST_STAGE_US);

  logic [2:0] sync_q;
  logic stage_clr, stage_run, stage_win;
  logic fall_ev, rise_ev, query_ev, od_tog_ev, idle_w, busy_w;

  owh_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  ({en_n_i, dat_i, rsel_i}),
    .q_o  (sync_q)
  );

  owh_stage_timer #(.LIMIT(STAGE_LEN)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (stage_clr),
    .run_i   (stage_run),
    .window_o(stage_win)
  );

  owh_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_s_i      (sync_q[2]),
    .dat_s_i     (sync_q[1]),
    .rsel_s_i    (sync_q[0]),
    .aux1_i      (aux1_i),
    .aux2_i      (aux2_i),
    .eng_done_i  (eng_done_i),
    .eng_result_i(eng_result_i),
    .stage_win_i (stage_win),
    .stage_clr_o (stage_clr),
    .stage_run_o (stage_run),
    .stat1_o     (stat1_o),
    .stat2_o     (stat2_o),
    .eng_start_o (eng_start_o),
    .eng_kind_o  (eng_kind_o),
    .speed_o     (speed_o),
    .fall_ev_o   (fall_ev),
    .rise_ev_o   (rise_ev),
    .query_ev_o  (query_ev),
    .od_tog_ev_o (od_tog_ev),
    .idle_o      (idle_w),
    .busy_o      (busy_w)
  );
endmodule

// File: rtl/owh_checker.sv
module owh_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       fall_ev,
  input logic       busy_w,
  input logic       idle_w,
  input logic       od_tog_ev,
  input logic       eng_start_o,
  input logic [1:0] eng_kind_o,
  input logic       stat1_o,
  input logic       stat2_o,
  input logic       aux1_i,
  input logic       aux2_i,
  input logic       speed_o
);
  a_r1_start_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start_o |-> $past(fall_ev));

  a_r2_bit_slot_low: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && eng_kind_o != 2'd2) |-> (!stat1_o && !stat2_o));

  a_r3_reset_out1_low: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && eng_kind_o == 2'd2) |-> !stat1_o);

  a_r7_idle_follows_aux: assert property (@(posedge clk) disable iff (!rst_n)
    idle_w |-> (stat1_o == aux1_i && stat2_o == aux2_i));

  a_r8_speed_only_on_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    !od_tog_ev |=> $stable(speed_o));

  a_r9_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start_o |=> !eng_start_o);

  a_r9_kind_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && $past(busy_w)) |-> $stable(eng_kind_o));
endmodule

bind owh_host_seq owh_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fall_ev    (fall_ev),
  .busy_w     (busy_w),
  .idle_w     (idle_w),
  .od_tog_ev  (od_tog_ev),
  .eng_start_o(eng_start_o),
  .eng_kind_o (eng_kind_o),
  .stat1_o    (stat1_o),
  .stat2_o    (stat2_o),
  .aux1_i     (aux1_i),
  .aux2_i     (aux2_i),
  .speed_o    (speed_o)
);

// File: tb/owh_host_seq_test.sv
module owh_host_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int CPU        = 4;
  localparam int STAGE_US   = 2;
  localparam int STAGE_EXP  = CPU * STAGE_US;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_n = 1'b1, dat = 1'b1, rsel = 1'b1, aux1 = 1'b1, aux2 = 1'b1;
  logic eng_done = 1'b0, eng_result = 1'b1;
  logic stat1, stat2, eng_start, speed;
  logic [1:0] eng_kind;

  int nchk = 0, nfail = 0;
  int eng_delay = 10;
  logic eng_res_cfg = 1'b1;
  int ecnt = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  owh_host_seq #(.CLK_PER_US(CPU), .RST_STAGE_US(STAGE_US)) uut (
    .clk(clk), .rst_n(rst_n), .en_n_i(en_n), .dat_i(dat), .rsel_i(rsel),
    .aux1_i(aux1), .aux2_i(aux2), .eng_done_i(eng_done), .eng_result_i(eng_result),
    .stat1_o(stat1), .stat2_o(stat2), .eng_start_o(eng_start),
    .eng_kind_o(eng_kind), .speed_o(speed)
  );

  // timing engine model
  always @(posedge clk) begin
    eng_done <= 1'b0;
    if (eng_start) ecnt <= eng_delay;
    else if (ecnt > 0) begin
      ecnt <= ecnt - 1;
      if (ecnt == 1) begin
        eng_done   <= 1'b1;
        eng_result <= eng_res_cfg;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_stat(input string tag, input logic e1, input logic e2);
    chk(stat1 === e1 && stat2 === e2, tag, {stat1, stat2}, {e1, e2});
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_start(output bit got, output logic [1:0] kind);
    got = 0; kind = 2'd3;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (eng_start) begin got = 1; kind = eng_kind; break; end
    end
  endtask

  task automatic finish_slot(input logic res);
    // done: pass-through (R4)
    chk_stat("R4 done follows aux 11", 1'b1, 1'b1);
    aux1 = 1'b0; #1;
    chk_stat("R4 done follows aux 01", 1'b0, 1'b1);
    aux1 = 1'b1;
    dat = 1'b0; cycles(5);
    if (!res) chk_stat("R5 low result forced low", 1'b0, 1'b0);
    else      chk_stat("R6 high result passes aux", 1'b1, 1'b1);
    en_n = 1'b1; cycles(5);
    chk_stat("R7 enable release follows aux", 1'b1, 1'b1);
    aux2 = 1'b0; #1;
    chk_stat("R7 idle follows aux 10", 1'b1, 1'b0);
    aux2 = 1'b1; dat = 1'b1; rsel = 1'b1; cycles(3);
  endtask

  task automatic t_reset_state();
    chk(speed === 1'b0, "R8 speed after reset", speed, 0);
    chk(eng_start === 1'b0, "R1 no start after reset", eng_start, 0);
    aux1 = 1'b0; aux2 = 1'b1; #1;
    chk_stat("R7 reset pass-through", 1'b0, 1'b1);
    aux1 = 1'b1; cycles(1);
  endtask

  task automatic t_bit(input logic d, input logic res, input logic [1:0] kexp);
    bit got; logic [1:0] k;
    eng_delay = 12; eng_res_cfg = res;
    dat = d; rsel = 1'b1; cycles(1);
    en_n = 1'b0;
    wait_start(got, k);
    chk(got, "R1 bit slot start", got, 1);
    chk(k === kexp, "R1 bit slot kind", k, kexp);
    chk_stat("R2 bit slot both low", 1'b0, 1'b0);
    dat = 1'b1; cycles(3);
    chk_stat("R2 bit slot still low", 1'b0, 1'b0);
    cycles(16);
    finish_slot(res);
  endtask

  task automatic t_reset(input logic res);
    bit got; logic [1:0] k; int n;
    eng_delay = 30; eng_res_cfg = res;
    dat = 1'b1; rsel = 1'b0; cycles(1);
    en_n = 1'b0;
    wait_start(got, k);
    chk(got && k === 2'd2, "R1 reset start kind", k, 2);
    chk_stat("R3 reset initial pattern", 1'b0, 1'b1);
    n = 0;
    while (stat2 === 1'b1 && n < 100) begin n++; @(negedge clk); end
    chk(n == STAGE_EXP, "R3 stage length", n, STAGE_EXP);
    chk_stat("R3 after stage both low", 1'b0, 1'b0);
    rsel = 1'b1; cycles(30);
    finish_slot(res);
  endtask

  task automatic t_coincide();
    bit got; logic [1:0] k; int starts;
    eng_delay = STAGE_EXP - 1; eng_res_cfg = 1'b1;
    dat = 1'b1; rsel = 1'b0; cycles(1);
    en_n = 1'b0;
    wait_start(got, k);
    chk(got, "R4 coincide start", got, 1);
    rsel = 1'b1; starts = 0;
    for (int i = 0; i < STAGE_EXP + 6; i++) begin
      @(negedge clk); if (eng_start) starts++;
    end
    chk(starts == 0, "R4 coincide no extra start", starts, 0);
    finish_slot(1'b1);
  endtask

  task automatic t_od();
    int starts = 0;
    dat = 1'b0; rsel = 1'b0; cycles(1);
    en_n = 1'b0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (eng_start) starts++; end
    chk(starts == 0, "R8 toggle starts no slot", starts, 0);
    chk(speed === 1'b1, "R8 toggle sets speed", speed, 1);
    aux2 = 1'b0; #1;
    chk_stat("R8 set passes aux", 1'b1, 1'b0);
    aux2 = 1'b1;
    en_n = 1'b1; cycles(5);
    en_n = 1'b0; cycles(6);
    chk(speed === 1'b0, "R8 toggle clears speed", speed, 0);
    chk_stat("R8 clear reports low", 1'b0, 1'b0);
    en_n = 1'b1; cycles(5);
    chk_stat("R7 after clear follows aux", 1'b1, 1'b1);
    dat = 1'b1; rsel = 1'b1; cycles(3);
  endtask

  task automatic t_ignore();
    bit got; logic [1:0] k; int starts = 0;
    eng_delay = 45; eng_res_cfg = 1'b1;
    dat = 1'b1; rsel = 1'b1; cycles(1);
    en_n = 1'b0;
    wait_start(got, k);
    chk(got && k === 2'd0, "R9 first start", k, 0);
    en_n = 1'b1;
    for (int i = 0; i < 4; i++) begin @(negedge clk); if (eng_start) starts++; end
    rsel = 1'b0; en_n = 1'b0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (eng_start) starts++; end
    chk(starts == 0, "R9 no restart while busy", starts, 0);
    chk(eng_kind === 2'd0, "R9 kind held", eng_kind, 0);
    chk_stat("R9 bit pattern kept", 1'b0, 1'b0);
    rsel = 1'b1; cycles(40);
    finish_slot(1'b1);
  endtask

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(2);
    t_reset_state();
    t_bit(1'b1, 1'b1, 2'd0);
    t_bit(1'b1, 1'b0, 2'd0);
    t_bit(1'b0, 1'b0, 2'd1);
    t_reset(1'b0);
    t_reset(1'b1);
    t_coincide();
    t_od();
    t_ignore();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule